// File: doc/BRIEF.md
# Prefetch Queue Static Branch Predictor

This block holds instructions between a 64-bit fetch port and an in-order integer pipeline. Each fetch cycle brings a pair of 32-bit words into a four-deep queue. The decoder takes one word per cycle from the oldest slot, together with predecode flags, a static taken/not-taken guess and the computed branch target.

In every cycle the two oldest queue slots are examined together. A slot can be the landing place of a branch because of code alignment, a stalled decoder or one branch following another. Because two slots are examined, none of these cases lets a branch slip past unpredicted. A branch predicted taken sends a one-cycle redirect to fetch and discards every younger queued word. A mispredict reported by execute empties the queue and redirects fetch to the corrected address. Each branch is judged only once, so a branch that sits in the queue behind a stalled decoder does not redirect fetch a second time.

Top module: `pfq_predictor`

## Requirements
- R1: After reset the queue is empty. `decValid`, `fetchFull` and `fetchRedirect` are all low.
- R2: A fetch at an 8-byte-aligned address enqueues two words. The low half of `fetchData` goes first, with pc `fetchAddr`, and the high half follows with pc `fetchAddr+4`. The decoder receives words in queue order, and a word held by a low `decReady` stays on the outputs unchanged.
- R3: A fetch whose address has bit 2 set enqueues only the high half of `fetchData`, with pc `fetchAddr`.
- R4: A word is a branch when bits [27:25] are 101 and the condition field [31:28] is not 1111. An always-condition branch (1110) is predicted taken. Any other branch is predicted taken exactly when offset bit 23 is set (backward). Non-branches report branch 0 and taken 0.
- R5: The target equals pc + 8 plus the sign-extended 24-bit offset [23:0] shifted left by two. The decoder outputs carry it, and so does a predicted redirect.
- R6: A not-yet-judged taken branch in either of the two oldest slots raises `fetchRedirect` in the same cycle, with its target. Every younger slot is discarded, and a fetch offered in that cycle is not enqueued.
- R7: When both of the two oldest slots hold not-yet-judged taken branches, the older one redirects and the younger one never reaches the decoder.
- R8: A branch redirects at most once. While a redirecting branch waits behind a stalled decoder, no further redirect is raised.
- R9: `mispredictValid` empties the queue and drives `fetchRedirect` with `mispredictPc`, overriding any predicted redirect. In that cycle `decValid` is low and a fetch offered in the same cycle is dropped.
- R10: `fetchFull` is high whenever fewer than two slots are free. A fetch offered while it is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch pair offered this cycle |
| fetchAddr | input | 32 | Address of the first word delivered |
| fetchData | input | 64 | Two instruction words, lower address in bits [31:0] |
| fetchFull | output | 1 | Fewer than two free slots; fetch must hold |
| fetchRedirect | output | 1 | One-cycle request to restart fetch |
| fetchRedirectPc | output | 32 | Restart address |
| decValid | output | 1 | Oldest slot offered to the decoder |
| decReady | input | 1 | Decoder accepts the offered word |
| decInstr | output | 32 | Offered instruction word |
| decPc | output | 32 | Its address |
| decIsBranch | output | 1 | Predecode: word is a branch |
| decPredTaken | output | 1 | Static prediction |
| decTarget | output | 32 | Computed branch target |
| mispredictValid | input | 1 | Execute reports a wrong path |
| mispredictPc | input | 32 | Correct address to resume from |

## Verification
A predicted redirect can fall in the same cycle as other events. It can land with a fetch return, with a dequeue from the oldest slot, and with a mispredict from execute. The bench holds the decoder stalled so that a backward branch sits in the second slot. It then offers a new fetch pair, or asserts a mispredict, in exactly the cycle the branch is judged. The redirect address is compared in that cycle. The scoreboard then shows whether only the surviving older words reach the decoder, with neither the dropped pair nor the discarded younger branch among them.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int INSTR_W  = 32;
  localparam int POS_W    = 4;

  typedef struct packed {
    logic             pop;
    logic             push;
    logic             upperOnly;
    logic [POS_W-1:0] writePos;
  } pfqStrobe_t;

  function automatic logic isBranchWord(input logic [INSTR_W-1:0] w);
    return (w[27:25] == 3'b101) && (w[31:28] != 4'hF);
  endfunction

  function automatic logic staticTaken(input logic [INSTR_W-1:0] w);
    return isBranchWord(w) && ((w[31:28] == 4'hE) || w[23]);
  endfunction
endpackage

// File: rtl/pfq_target_decode.sv
module pfq_target_decode
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  pc,
  output logic               isBranch,
  output logic               predTaken,
  output logic [ADDR_W-1:0]  target
);
  localparam int EXT_W = ADDR_W - 26;

  logic [ADDR_W-1:0] byteOffset;

  always_comb begin
    byteOffset = {{EXT_W{instr[23]}}, instr[23:0], 2'b00};
    target     = pc + ADDR_W'(8) + byteOffset;
    isBranch   = isBranchWord(instr);
    predTaken  = staticTaken(instr);
  end
endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pfqStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]            fetchAddr,
  input  logic [2*INSTR_W-1:0]         fetchData,
  output logic [1:0][INSTR_W-1:0]      laneInstr,
  output logic [1:0][ADDR_W-1:0]       lanePc,
  output logic [1:0]                   laneBranch,
  output logic [1:0]                   laneTaken,
  output logic [1:0][ADDR_W-1:0]       laneTarget,
  output logic [1:0]                   laneJudged
);
  localparam int SCAN = 2;

  logic [DEPTH-1:0][INSTR_W-1:0] instrQ;
  logic [DEPTH-1:0][ADDR_W-1:0]  pcQ;
  logic [DEPTH-1:0]              judgedQ;
  logic [DEPTH-1:0]              judgedMid;

  logic [INSTR_W-1:0] lowWord;
  logic [INSTR_W-1:0] highWord;
  logic [ADDR_W-1:0]  highPc;
  logic [POS_W-1:0]   writePosHi;

  assign lowWord    = fetchData[INSTR_W-1:0];
  assign highWord   = fetchData[2*INSTR_W-1:INSTR_W];
  assign highPc     = strobe.upperOnly ? fetchAddr : fetchAddr + ADDR_W'(4);
  assign writePosHi = strobe.writePos + POS_W'(1);

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : gSlot
      localparam logic SCANNED = (i < SCAN);
      logic [INSTR_W-1:0] shInstr;
      logic [ADDR_W-1:0]  shPc;
      logic               shJudged;
      logic [INSTR_W-1:0] nxInstr;
      logic [ADDR_W-1:0]  nxPc;
      logic               nxJudged;

      assign judgedMid[i] = judgedQ[i] | SCANNED;

      if (i < DEPTH - 1) begin : gShift
        always_comb begin
          shInstr  = strobe.pop ? instrQ[i+1]    : instrQ[i];
          shPc     = strobe.pop ? pcQ[i+1]       : pcQ[i];
          shJudged = strobe.pop ? judgedMid[i+1] : judgedMid[i];
        end
      end else begin : gLast
        always_comb begin
          shInstr  = instrQ[i];
          shPc     = pcQ[i];
          shJudged = judgedMid[i];
        end
      end

      always_comb begin
        nxInstr  = shInstr;
        nxPc     = shPc;
        nxJudged = shJudged;
        if (strobe.push) begin
          if (strobe.upperOnly) begin
            if (strobe.writePos == POS_W'(i)) begin
              nxInstr  = highWord;
              nxPc     = highPc;
              nxJudged = 1'b0;
            end
          end else begin
            if (strobe.writePos == POS_W'(i)) begin
              nxInstr  = lowWord;
              nxPc     = fetchAddr;
              nxJudged = 1'b0;
            end else if (writePosHi == POS_W'(i)) begin
              nxInstr  = highWord;
              nxPc     = highPc;
              nxJudged = 1'b0;
            end
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          instrQ[i]  <= '0;
          pcQ[i]     <= '0;
          judgedQ[i] <= 1'b0;
        end else begin
          instrQ[i]  <= nxInstr;
          pcQ[i]     <= nxPc;
          judgedQ[i] <= nxJudged;
        end
      end
    end

    for (i = 0; i < SCAN; i++) begin : gScan
      assign laneInstr[i]  = instrQ[i];
      assign lanePc[i]     = pcQ[i];
      assign laneJudged[i] = judgedQ[i];
      pfq_target_decode #(.ADDR_W(ADDR_W)) uDecode (
        .instr    (instrQ[i]),
        .pc       (pcQ[i]),
        .isBranch (laneBranch[i]),
        .predTaken(laneTaken[i]),
        .target   (laneTarget[i])
      );
    end
  endgenerate
endmodule

// File: rtl/pfq_control.sv
module pfq_control
  import pfq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic       fetchUpperOnly,
  input  logic       decReady,
  input  logic       mispredictValid,
  input  logic [1:0] laneTaken,
  input  logic [1:0] laneJudged,
  output pfqStrobe_t strobe,
  output logic       decValid,
  output logic       fetchFull,
  output logic       predRedirect,
  output logic       redirectFromB
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] keepCnt;
  logic [CNT_W-1:0] afterPop;
  logic [CNT_W-1:0] cntNext;
  logic             hasA;
  logic             hasB;
  logic             redirA;
  logic             redirB;
  logic             accept;

  always_comb begin
    hasA      = cnt >= CNT_W'(1);
    hasB      = cnt >= CNT_W'(2);
    fetchFull = cnt > CNT_W'(DEPTH - 2);
    redirA    = hasA && !mispredictValid && laneTaken[0] && !laneJudged[0];
    redirB    = hasB && !mispredictValid && laneTaken[1] && !laneJudged[1] && !redirA;
    predRedirect  = redirA || redirB;
    redirectFromB = redirB;

    if (mispredictValid) keepCnt = '0;
    else if (redirA)     keepCnt = CNT_W'(1);
    else if (redirB)     keepCnt = CNT_W'(2);
    else                 keepCnt = cnt;

    decValid = hasA && !mispredictValid;
    strobe.pop = decValid && decReady;
    afterPop = keepCnt - (strobe.pop ? CNT_W'(1) : CNT_W'(0));

    accept = fetchValid && !fetchFull && !mispredictValid && !predRedirect;
    strobe.push      = accept;
    strobe.upperOnly = fetchUpperOnly;
    strobe.writePos  = POS_W'(afterPop);

    cntNext = afterPop;
    if (accept) cntNext = afterPop + (fetchUpperOnly ? CNT_W'(1) : CNT_W'(2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNext;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  assert_mispredict_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    mispredictValid |=> (cnt == '0));

  assert_flush_younger_R6: assert property (@(posedge clk) disable iff (!rstN)
    predRedirect |=> (cnt <= CNT_W'(2)));

  assert_single_redirect_R8: assert property (@(posedge clk) disable iff (!rstN)
    predRedirect |=> !predRedirect);
endmodule

// File: rtl/pfq_predictor.sv
module pfq_predictor
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [2*INSTR_W-1:0] fetchData,
  output logic                 fetchFull,
  output logic                 fetchRedirect,
  output logic [ADDR_W-1:0]    fetchRedirectPc,
  output logic                 decValid,
  input  logic                 decReady,
  output logic [INSTR_W-1:0]   decInstr,
  output logic [ADDR_W-1:0]    decPc,
  output logic                 decIsBranch,
  output logic                 decPredTaken,
  output logic [ADDR_W-1:0]    decTarget,
  input  logic                 mispredictValid,
  input  logic [ADDR_W-1:0]    mispredictPc
);
  pfqStrobe_t                strobe;
  logic [1:0][INSTR_W-1:0]   laneInstr;
  logic [1:0][ADDR_W-1:0]    lanePc;
  logic [1:0]                laneBranch;
  logic [1:0]                laneTaken;
  logic [1:0][ADDR_W-1:0]    laneTarget;
  logic [1:0]                laneJudged;
  logic                      predRedirect;
  logic                      redirectFromB;

  pfq_control #(.DEPTH(DEPTH)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .fetchValid     (fetchValid),
    .fetchUpperOnly (fetchAddr[2]),
    .decReady       (decReady),
    .mispredictValid(mispredictValid),
    .laneTaken      (laneTaken),
    .laneJudged     (laneJudged),
    .strobe         (strobe),
    .decValid       (decValid),
    .fetchFull      (fetchFull),
    .predRedirect   (predRedirect),
    .redirectFromB  (redirectFromB)
  );

  pfq_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fetchAddr (fetchAddr),
    .fetchData (fetchData),
    .laneInstr (laneInstr),
    .lanePc    (lanePc),
    .laneBranch(laneBranch),
    .laneTaken (laneTaken),
    .laneTarget(laneTarget),
    .laneJudged(laneJudged)
  );

  always_comb begin
    fetchRedirect   = mispredictValid || predRedirect;
    fetchRedirectPc = mispredictValid ? mispredictPc
                    : (redirectFromB ? laneTarget[1] : laneTarget[0]);
    decInstr     = laneInstr[0];
    decPc        = lanePc[0];
    decIsBranch  = laneBranch[0];
    decPredTaken = laneTaken[0];
    decTarget    = laneTarget[0];
  end

  assert_hold_head_R2: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decReady) |=> (mispredictValid ||
      (decValid && $stable(decPc) && $stable(decInstr))));

  assert_mispredict_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    mispredictValid |-> (fetchRedirect && !decValid && fetchRedirectPc == mispredictPc));
endmodule

// File: tb/tb_pfq_predictor.sv
module tb_pfq_predictor;
  typedef struct {
    logic [31:0] instr;
    logic [31:0] pc;
    logic        isBr;
    logic        taken;
    logic [31:0] target;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [63:0] fetchData = '0;
  logic        fetchFull;
  logic        fetchRedirect;
  logic [31:0] fetchRedirectPc;
  logic        decValid;
  logic        decReady = 1'b0;
  logic [31:0] decInstr;
  logic [31:0] decPc;
  logic        decIsBranch;
  logic        decPredTaken;
  logic [31:0] decTarget;
  logic        mispredictValid = 1'b0;
  logic [31:0] mispredictPc = '0;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  item_t expQ[$];

  localparam logic [31:0] NOP   = 32'hE1A00000;
  localparam logic [31:0] BNE_F = 32'h1A000004;
  localparam logic [31:0] BLT_B = 32'hBAFFFFFE;
  localparam logic [31:0] B_AL  = 32'hEA000004;
  localparam logic [31:0] BEQ_B = 32'h0AFFFFFC;

  always #4 clk = ~clk;

  pfq_predictor dut (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .fetchFull(fetchFull), .fetchRedirect(fetchRedirect), .fetchRedirectPc(fetchRedirectPc),
    .decValid(decValid), .decReady(decReady), .decInstr(decInstr), .decPc(decPc),
    .decIsBranch(decIsBranch), .decPredTaken(decPredTaken), .decTarget(decTarget),
    .mispredictValid(mispredictValid), .mispredictPc(mispredictPc)
  );

  function automatic item_t mkItem(input logic [31:0] pc, input logic [31:0] w);
    item_t it;
    it.instr  = w;
    it.pc     = pc;
    it.isBr   = (w[27:25] == 3'b101) && (w[31:28] != 4'hF);
    it.taken  = it.isBr && ((w[31:28] == 4'hE) || w[23]);
    it.target = pc + 32'd8 + {{6{w[23]}}, w[23:0], 2'b00};
    return it;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit fv, input logic [31:0] fa, input logic [63:0] fd,
                     input bit rdy, input bit mp, input logic [31:0] mpc);
    @(negedge clk);
    #1;
    fetchValid = fv; fetchAddr = fa; fetchData = fd;
    decReady = rdy; mispredictValid = mp; mispredictPc = mpc;
    #1;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 8; k++) cyc(0, '0, '0, 1, 0, '0);
    chk({req, " scoreboard empty"}, expQ.size(), 0);
  endtask

  // monitor: pops expected items as the decoder accepts words
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rstN && decValid && decReady) begin
        if (expQ.size() == 0) begin
          chk("R2/R7 unexpected word pc", decPc, 32'hFFFFFFFF);
        end else begin
          item_t e;
          e = expQ.pop_front();
          chk("R2 instr", decInstr, e.instr);
          chk("R2 pc", decPc, e.pc);
          chk("R4 isBranch", {31'b0, decIsBranch}, {31'b0, e.isBr});
          chk("R4 predTaken", {31'b0, decPredTaken}, {31'b0, e.taken});
          if (e.isBr) chk("R5 target", decTarget, e.target);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) @(negedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 decValid", {31'b0, decValid}, 0);
    chk("R1 fetchFull", {31'b0, fetchFull}, 0);
    chk("R1 fetchRedirect", {31'b0, fetchRedirect}, 0);

    // R2 aligned pair, decoder ready
    expQ.push_back(mkItem(32'h100, 32'hE0811002));
    expQ.push_back(mkItem(32'h104, 32'hE2433001));
    cyc(1, 32'h100, {32'hE2433001, 32'hE0811002}, 1, 0, '0);
    drain("R2");

    // R3 unaligned fetch keeps only upper word, then an aligned pair
    expQ.push_back(mkItem(32'h20C, 32'hE3A00011));
    cyc(1, 32'h20C, {32'hE3A00011, 32'hE3A000FF}, 1, 0, '0);
    expQ.push_back(mkItem(32'h210, 32'hE3A00012));
    expQ.push_back(mkItem(32'h214, 32'hE3A00013));
    cyc(1, 32'h210, {32'hE3A00013, 32'hE3A00012}, 1, 0, '0);
    drain("R3");

    // R4 forward conditional branch in second slot: not taken, no redirect
    expQ.push_back(mkItem(32'h300, NOP));
    expQ.push_back(mkItem(32'h304, BNE_F));
    cyc(1, 32'h300, {BNE_F, NOP}, 0, 0, '0);
    cyc(0, '0, '0, 0, 0, '0);
    chk("R4 forward branch no redirect", {31'b0, fetchRedirect}, 0);
    drain("R4");

    // R6 backward branch in second slot with a fetch in the same cycle; R8 once
    expQ.push_back(mkItem(32'h400, NOP));
    expQ.push_back(mkItem(32'h404, BLT_B));
    cyc(1, 32'h400, {BLT_B, NOP}, 0, 0, '0);
    cyc(1, 32'h408, {NOP, NOP}, 0, 0, '0);
    chk("R6 redirect raised", {31'b0, fetchRedirect}, 1);
    chk("R5 redirect target", fetchRedirectPc, 32'h404);
    cyc(0, '0, '0, 0, 0, '0);
    chk("R8 no second redirect", {31'b0, fetchRedirect}, 0);
    cyc(0, '0, '0, 0, 0, '0);
    chk("R8 still no redirect", {31'b0, fetchRedirect}, 0);
    drain("R6");

    // R7 two taken branches: older wins, younger discarded
    expQ.push_back(mkItem(32'h500, B_AL));
    cyc(1, 32'h500, {BEQ_B, B_AL}, 0, 0, '0);
    cyc(0, '0, '0, 0, 0, '0);
    chk("R7 redirect raised", {31'b0, fetchRedirect}, 1);
    chk("R7 older target", fetchRedirectPc, 32'h518);
    drain("R7");

    // R10 full flag and ignored fetch while full
    expQ.push_back(mkItem(32'h600, 32'hE1A01001));
    expQ.push_back(mkItem(32'h604, 32'hE1A02002));
    expQ.push_back(mkItem(32'h608, 32'hE1A03003));
    expQ.push_back(mkItem(32'h60C, 32'hE1A04004));
    cyc(1, 32'h600, {32'hE1A02002, 32'hE1A01001}, 0, 0, '0);
    cyc(1, 32'h608, {32'hE1A04004, 32'hE1A03003}, 0, 0, '0);
    chk("R10 not full with two used", {31'b0, fetchFull}, 0);
    cyc(1, 32'h610, {32'hE1A06006, 32'hE1A05005}, 0, 0, '0);
    chk("R10 full with four used", {31'b0, fetchFull}, 1);
    drain("R10");
    chk("R10 full clears when empty", {31'b0, fetchFull}, 0);

    // R9 mispredict overrides predicted redirect and clears the queue
    cyc(1, 32'h700, {BLT_B, NOP}, 0, 0, '0);
    cyc(1, 32'h708, {NOP, NOP}, 1, 1, 32'h1234);
    chk("R9 redirect raised", {31'b0, fetchRedirect}, 1);
    chk("R9 redirect pc", fetchRedirectPc, 32'h1234);
    chk("R9 decValid low", {31'b0, decValid}, 0);
    cyc(0, '0, '0, 1, 0, '0);
    chk("R9 queue empty", {31'b0, decValid}, 0);
    drain("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule